// File: doc/BRIEF.md
# Chunked Mailbox Transfer Sequencer

This block is a bus master that moves an image from a source memory into a device through a small register mailbox, one fixed-size chunk per transaction. Software or a controlling state machine pulses `start` with the image length in bytes. The sequencer builds each request object itself: two 64-bit headers, then the chunk dwords read from the source memory. It then raises the go bit and polls the status register at a fixed interval. Once the device reports ready, it drains and acknowledges the four-word response.

The device picks every chunk. Each response carries the byte offset of the next chunk it wants, and the sequencer sends exactly that chunk. The run ends when the device returns the all-ones end marker, when a check fails, or when the permitted number of transactions has been used up. The result is held on `err_code` and announced by a one-cycle `done` pulse. `bytes_sent` keeps a running byte total.

The mailbox registers sit at byte offsets 0x0 (control), 0x4 (status), 0x8 (write data) and 0xC (read data). Each register access holds `reg_req` until the endpoint returns `reg_ack`. Read data is taken in the acknowledging cycle. The source memory is read asynchronously at dword address `src_addr`.

Top module: `mbx_xfer_seq`

## Requirements
- R1: After reset `busy`, `done`, `err_code`, `bytes_sent` and `reg_req` are all 0. A `start` pulse while idle raises `busy`. The end of the run gives one `done` cycle, after which `busy` falls and `err_code` holds its value until the next start.
- R2: Each transaction writes, in order, to 0x8: HDR_TAG, the mailbox size in dwords ((16 + CHUNK_BYTES)/4), the load command 3, 0, and then the chunk dwords from source dword address offset/4 upward. It finishes with the write 0x8000_0000 to 0x0.
- R3: After the go write, the status register 0x4 is read once per POLL_GAP-cycle interval. Polling stops at the first read with bit 31 (ready) set.
- R4: At most TIMEOUT_POLLS status reads are made per transaction. If bit 2 is set in the final status read, the result is I/O error (code 1). If no read showed ready, the result is timeout (code 2).
- R5: The response is fetched as four reads of 0xC: header low, header high, next offset, status. Each read is followed by a write of 0 to 0xC before the next access.
- R6: If the response header is not {high = 4, low = HDR_TAG}, the run ends with bad header (code 3).
- R7: If the next offset is not 0xFFFF_FFFF and exceeds the image length, the run ends with bad offset (code 4). An offset equal to the length is accepted.
- R8: If the response status has bit 2 set, the run ends with device error (code 5).
- R9: The first chunk is taken at offset 0 and every later chunk at the offset the device returned. An offset of 0xFFFF_FFFF ends the run with code 0.
- R10: If MAX_XACT transactions have completed and no end marker has arrived, the run ends with retry limit (code 6) and sends nothing more.
- R11: `bytes_sent` is cleared at start and grows by CHUNK_BYTES for every go write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a transfer (idle only) |
| image_len | input | 32 | Image length in bytes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_code | output | 3 | Result code (0 none, 1 I/O, 2 timeout, 3 header, 4 offset, 5 device, 6 retry) |
| bytes_sent | output | 32 | Running total of chunk bytes sent |
| src_addr | output | SRC_AW | Source memory dword address |
| src_data | input | 32 | Source memory read data |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | Access is a write |
| reg_addr | output | 4 | Register byte offset |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, valid with ack |
| reg_ack | input | 1 | Access accepted |

## Verification
A wrong write index or a corrupted offset register shows up at the go write of the same transaction. The mailbox model compares the whole captured request against the chunk it asked for, so a misordered header or a chunk taken from the wrong address is reported within about twenty cycles. A broken poll counter shows as a wrong number of status reads before the run ends, or as a timeout code in place of an I/O code. A decision slip in the response checks leaves the wrong `err_code` or `bytes_sent` at the `done` pulse, at most one transaction after the bad response.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_IO      = 3'd1,
        ERR_TIMEOUT = 3'd2,
        ERR_HEADER  = 3'd3,
        ERR_OFFSET  = 3'd4,
        ERR_DEVICE  = 3'd5,
        ERR_RETRY   = 3'd6
    } mbx_err_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DECIDE,
        S_SEND,
        S_GAP,
        S_POLL,
        S_RESP,
        S_EVAL,
        S_FINISH
    } seq_state_e;

    localparam logic [3:0]  REG_CTRL   = 4'h0;
    localparam logic [3:0]  REG_STAT   = 4'h4;
    localparam logic [3:0]  REG_WR     = 4'h8;
    localparam logic [3:0]  REG_RD     = 4'hC;
    localparam logic [31:0] CMD_LOAD   = 32'd3;
    localparam logic [31:0] GO_WORD    = 32'h8000_0000;
    localparam logic [31:0] END_MARK   = 32'hFFFF_FFFF;
    localparam int          RDY_BIT    = 31;
    localparam int          FAULT_BIT  = 2;

endpackage

// File: rtl/mbx_req_builder.sv
module mbx_req_builder
    import mbx_pkg::*;
#(
    parameter int          CHUNK_DW = 4,
    parameter int          IDX_W    = 4,
    parameter int          SRC_AW   = 10,
    parameter logic [31:0] HDR_TAG  = 32'h000B_0001
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [SRC_AW-1:0] base_dw,
    input  logic [31:0]       src_data,
    output logic [SRC_AW-1:0] src_addr,
    output logic [3:0]        wr_addr,
    output logic [31:0]       wr_data
);
    localparam int          NW      = 4 + CHUNK_DW;
    localparam logic [31:0] SIZE_DW = 32'(4 + CHUNK_DW);

    logic [IDX_W-1:0] rel;

    always_comb begin
        rel      = idx - IDX_W'(4);
        src_addr = base_dw + SRC_AW'(rel);
        wr_addr  = REG_WR;
        wr_data  = src_data;
        if (idx == IDX_W'(0)) begin
            wr_data = HDR_TAG;
        end else if (idx == IDX_W'(1)) begin
            wr_data = SIZE_DW;
        end else if (idx == IDX_W'(2)) begin
            wr_data = CMD_LOAD;
        end else if (idx == IDX_W'(3)) begin
            wr_data = 32'd0;
        end else if (idx >= IDX_W'(NW)) begin
            wr_addr = REG_CTRL;
            wr_data = GO_WORD;
        end
    end
endmodule

// File: rtl/mbx_poll_timer.sv
module mbx_poll_timer #(
    parameter int POLL_GAP      = 4,
    parameter int TIMEOUT_POLLS = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic poll_taken,
    output logic gap_done,
    output logic last_poll
);
    localparam int GW = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;
    localparam int PW = $clog2(TIMEOUT_POLLS + 1);

    typedef struct packed {
        logic [GW-1:0] gap;
        logic [PW-1:0] polls;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        gap_done  = run && (tmr_q.gap == GW'(POLL_GAP - 1));
        last_poll = (tmr_q.polls == PW'(TIMEOUT_POLLS - 1));
        if (!run || gap_done) tmr_d.gap = '0;
        else                  tmr_d.gap = tmr_q.gap + GW'(1);
        if (clr)             tmr_d.polls = '0;
        else if (poll_taken) tmr_d.polls = tmr_q.polls + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    a_r4_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.polls <= PW'(TIMEOUT_POLLS));

    a_r3_gap_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        gap_done |=> (tmr_q.gap == '0));
endmodule

// File: rtl/mbx_resp_check.sv
module mbx_resp_check
    import mbx_pkg::*;
#(
    parameter logic [31:0] HDR_TAG = 32'h000B_0001
) (
    input  logic [31:0] hdr_lo,
    input  logic [31:0] hdr_hi,
    input  logic [31:0] next_off,
    input  logic        dev_fault,
    input  logic [31:0] image_len,
    output mbx_err_e    verdict
);
    logic hdr_bad, off_bad;

    always_comb begin
        hdr_bad = (hdr_lo != HDR_TAG) || (hdr_hi != 32'd4);
        off_bad = (next_off != END_MARK) && (next_off > image_len);
        if (hdr_bad)        verdict = ERR_HEADER;
        else if (off_bad)   verdict = ERR_OFFSET;
        else if (dev_fault) verdict = ERR_DEVICE;
        else                verdict = ERR_NONE;
    end
endmodule

// File: rtl/mbx_xfer_seq.sv
module mbx_xfer_seq
    import mbx_pkg::*;
#(
    parameter int          CHUNK_BYTES   = 16,
    parameter int          MAX_XACT      = 8,
    parameter int          POLL_GAP      = 4,
    parameter int          TIMEOUT_POLLS = 10000,
    parameter int          SRC_AW        = 10,
    parameter logic [31:0] HDR_TAG       = 32'h000B_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       image_len,
    output logic              busy,
    output logic              done,
    output logic [2:0]        err_code,
    output logic [31:0]       bytes_sent,
    output logic [SRC_AW-1:0] src_addr,
    input  logic [31:0]       src_data,
    output logic              reg_req,
    output logic              reg_we,
    output logic [3:0]        reg_addr,
    output logic [31:0]       reg_wdata,
    input  logic [31:0]       reg_rdata,
    input  logic              reg_ack
);
    localparam int CHUNK_DW = CHUNK_BYTES / 4;
    localparam int NW       = 4 + CHUNK_DW;
    localparam int IW_RAW   = $clog2(NW + 1);
    localparam int IDX_W    = (IW_RAW > 3) ? IW_RAW : 3;
    localparam int XW       = $clog2(MAX_XACT + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [31:0]      offset;
        logic [XW-1:0]    xacts;
        logic [31:0]      bytes;
        mbx_err_e         err;
        logic [31:0]      r_lo;
        logic [31:0]      r_hi;
        logic [31:0]      r_off;
        logic             r_fault;
    } seq_t;

    seq_t q, n;

    logic [3:0]  bld_addr;
    logic [31:0] bld_data;
    logic        tmr_clr, tmr_run, tmr_poll, gap_done, last_poll;
    mbx_err_e    verdict;

    mbx_req_builder #(
        .CHUNK_DW (CHUNK_DW),
        .IDX_W    (IDX_W),
        .SRC_AW   (SRC_AW),
        .HDR_TAG  (HDR_TAG)
    ) u_build (
        .idx      (q.idx),
        .base_dw  (q.offset[SRC_AW+1:2]),
        .src_data (src_data),
        .src_addr (src_addr),
        .wr_addr  (bld_addr),
        .wr_data  (bld_data)
    );

    mbx_poll_timer #(
        .POLL_GAP      (POLL_GAP),
        .TIMEOUT_POLLS (TIMEOUT_POLLS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (tmr_clr),
        .run        (tmr_run),
        .poll_taken (tmr_poll),
        .gap_done   (gap_done),
        .last_poll  (last_poll)
    );

    mbx_resp_check #(
        .HDR_TAG (HDR_TAG)
    ) u_check (
        .hdr_lo    (q.r_lo),
        .hdr_hi    (q.r_hi),
        .next_off  (q.r_off),
        .dev_fault (q.r_fault),
        .image_len (image_len),
        .verdict   (verdict)
    );

    always_comb begin
        n         = q;
        reg_req   = 1'b0;
        reg_we    = 1'b0;
        reg_addr  = REG_STAT;
        reg_wdata = 32'd0;
        tmr_clr   = 1'b0;
        tmr_run   = 1'b0;
        tmr_poll  = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    n.st     = S_DECIDE;
                    n.offset = 32'd0;
                    n.xacts  = '0;
                    n.bytes  = 32'd0;
                    n.err    = ERR_NONE;
                end
            end
            S_DECIDE: begin
                n.idx = '0;
                if (q.offset == END_MARK) begin
                    n.st = S_FINISH;
                end else if (q.xacts == XW'(MAX_XACT)) begin
                    n.err = ERR_RETRY;
                    n.st  = S_FINISH;
                end else begin
                    n.st = S_SEND;
                end
            end
            S_SEND: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_addr  = bld_addr;
                reg_wdata = bld_data;
                if (reg_ack) begin
                    if (q.idx == IDX_W'(NW)) begin
                        n.xacts = q.xacts + XW'(1);
                        n.bytes = q.bytes + 32'(CHUNK_BYTES);
                        tmr_clr = 1'b1;
                        n.st    = S_GAP;
                    end else begin
                        n.idx = q.idx + IDX_W'(1);
                    end
                end
            end
            S_GAP: begin
                tmr_run = 1'b1;
                if (gap_done) n.st = S_POLL;
            end
            S_POLL: begin
                reg_req = 1'b1;
                if (reg_ack) begin
                    tmr_poll = 1'b1;
                    if (reg_rdata[FAULT_BIT] && (reg_rdata[RDY_BIT] || last_poll)) begin
                        n.err = ERR_IO;
                        n.st  = S_FINISH;
                    end else if (reg_rdata[RDY_BIT]) begin
                        n.idx = '0;
                        n.st  = S_RESP;
                    end else if (last_poll) begin
                        n.err = ERR_TIMEOUT;
                        n.st  = S_FINISH;
                    end else begin
                        n.st = S_GAP;
                    end
                end
            end
            S_RESP: begin
                reg_req  = 1'b1;
                reg_we   = q.idx[0];
                reg_addr = REG_RD;
                if (reg_ack) begin
                    if (!q.idx[0]) begin
                        case (q.idx[2:1])
                            2'd0:    n.r_lo    = reg_rdata;
                            2'd1:    n.r_hi    = reg_rdata;
                            2'd2:    n.r_off   = reg_rdata;
                            default: n.r_fault = reg_rdata[FAULT_BIT];
                        endcase
                    end
                    if (q.idx == IDX_W'(7)) n.st = S_EVAL;
                    else                    n.idx = q.idx + IDX_W'(1);
                end
            end
            S_EVAL: begin
                if (verdict != ERR_NONE) begin
                    n.err = verdict;
                    n.st  = S_FINISH;
                end else begin
                    n.offset = q.r_off;
                    n.st     = S_DECIDE;
                end
            end
            S_FINISH: n.st = S_IDLE;
            default:  n.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign busy       = (q.st != S_IDLE);
    assign done       = (q.st == S_FINISH);
    assign err_code   = q.err;
    assign bytes_sent = q.bytes;

    a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r1_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r2_go_value: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we && reg_addr == REG_CTRL) |-> (reg_wdata == GO_WORD));

    a_r5_ack_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_ack && !reg_we && reg_addr == REG_RD)
        |=> (reg_req && reg_we && reg_addr == REG_RD && reg_wdata == 32'd0));

    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_we)));

    a_r10_xact_limit: assert property (@(posedge clk) disable iff (!rst_n)
        q.xacts <= XW'(MAX_XACT));
endmodule

// File: tb/mbx_xfer_seq_bench.sv
module mbx_xfer_seq_bench;
    localparam int          CB   = 16;
    localparam int          CDW  = CB / 4;
    localparam int          MX   = 4;
    localparam int          GAP  = 3;
    localparam int          TP   = 12;
    localparam int          SAW  = 6;
    localparam logic [31:0] TAG  = 32'h000B_0001;
    localparam logic [31:0] ENDM = 32'hFFFF_FFFF;

    typedef struct packed {
        logic [31:0] len;
        logic [31:0] o0;
        logic [31:0] o1;
        logic [31:0] o2;
        logic [3:0]  rdy;
        logic        serr;
        logic [2:0]  bad_hdr_at;
        logic [2:0]  dev_err_at;
        logic [2:0]  exp_err;
        logic [3:0]  exp_x;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{32'd64,  32'd16, 32'd32, ENDM,   4'd1,  1'b0, 3'd7, 3'd7, 3'd0, 4'd3}, // R9 chain
        '{32'd64,  ENDM,   ENDM,   ENDM,   4'd1,  1'b0, 3'd7, 3'd7, 3'd0, 4'd1}, // R9 single
        '{32'd64,  32'd64, ENDM,   ENDM,   4'd1,  1'b0, 3'd7, 3'd7, 3'd0, 4'd2}, // R7 equal ok
        '{32'd64,  32'd68, ENDM,   ENDM,   4'd1,  1'b0, 3'd7, 3'd7, 3'd4, 4'd1}, // R7 past end
        '{32'd64,  32'd48, ENDM,   ENDM,   4'd1,  1'b0, 3'd1, 3'd7, 3'd3, 4'd2}, // R6 header
        '{32'd64,  ENDM,   ENDM,   ENDM,   4'd1,  1'b0, 3'd7, 3'd0, 3'd5, 4'd1}, // R8 device
        '{32'd200, 32'd8,  32'd8,  32'd8,  4'd1,  1'b0, 3'd7, 3'd7, 3'd6, 4'd4}, // R10 retry
        '{32'd64,  ENDM,   ENDM,   ENDM,   4'd2,  1'b0, 3'd7, 3'd7, 3'd0, 4'd1}, // R3 slow ready
        '{32'd64,  ENDM,   ENDM,   ENDM,   4'd15, 1'b0, 3'd7, 3'd7, 3'd2, 4'd1}, // R4 timeout
        '{32'd64,  ENDM,   ENDM,   ENDM,   4'd1,  1'b1, 3'd7, 3'd7, 3'd1, 4'd1}, // R4 io ready
        '{32'd64,  ENDM,   ENDM,   ENDM,   4'd15, 1'b1, 3'd7, 3'd7, 3'd1, 4'd1}  // R4 io on timeout
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [31:0]       image_len;
    logic              busy, done;
    logic [2:0]        err_code;
    logic [31:0]       bytes_sent;
    logic [SAW-1:0]    src_addr;
    logic [31:0]       src_data;
    logic              reg_req, reg_we, reg_ack;
    logic [3:0]        reg_addr;
    logic [31:0]       reg_wdata, reg_rdata;

    always #5 clk = ~clk;

    function automatic logic [31:0] memval(input logic [SAW-1:0] a);
        return 32'hA500_0000 + 32'(a) * 32'h0101_0101;
    endfunction

    assign src_data = memval(src_addr);

    mbx_xfer_seq #(
        .CHUNK_BYTES   (CB),
        .MAX_XACT      (MX),
        .POLL_GAP      (GAP),
        .TIMEOUT_POLLS (TP),
        .SRC_AW        (SAW),
        .HDR_TAG       (TAG)
    ) u_mbx_xfer_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .image_len  (image_len),
        .busy       (busy),
        .done       (done),
        .err_code   (err_code),
        .bytes_sent (bytes_sent),
        .src_addr   (src_addr),
        .src_data   (src_data),
        .reg_req    (reg_req),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_ack    (reg_ack)
    );

    // Mailbox endpoint model
    vec_t        cur;
    int          dchecks, dfails;
    int          wr_cnt, go_cnt, polls, rd_ptr;
    logic        need_zero;
    logic [31:0] dev_off;
    logic [31:0] cap [16];
    logic [31:0] rsp [4];

    always @(posedge clk) begin
        if (!rst_n) begin
            reg_ack   <= 1'b0;
            reg_rdata <= 32'd0;
            wr_cnt    <= 0; go_cnt <= 0; polls <= 0; rd_ptr <= 0;
            need_zero <= 1'b0;
            dev_off   <= 32'd0;
        end else begin
            if (start) begin
                wr_cnt <= 0; go_cnt <= 0; polls <= 0; rd_ptr <= 0;
                need_zero <= 1'b0; dev_off <= 32'd0;
            end
            if (reg_req && !reg_ack) begin
                reg_ack <= 1'b1;
                if (reg_we && reg_addr == 4'h8) begin
                    cap[wr_cnt] <= reg_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else if (reg_we && reg_addr == 4'h0) begin
                    automatic logic bad = (reg_wdata != 32'h8000_0000) || (wr_cnt != 4 + CDW)
                        || (cap[0] != TAG) || (cap[1] != 32'(4 + CDW))
                        || (cap[2] != 32'd3) || (cap[3] != 32'd0);
                    for (int i = 0; i < CDW; i++)
                        if (cap[4+i] != memval(SAW'(dev_off[31:2]) + SAW'(i))) bad = 1'b1;
                    dchecks <= dchecks + 1;
                    if (bad) begin
                        dfails <= dfails + 1;
                        $display("FAIL R2 request xact %0d act=%0h exp=%0h", go_cnt, cap[4], memval(SAW'(dev_off[31:2])));
                    end
                    rsp[0] <= TAG;
                    rsp[1] <= (3'(go_cnt) == cur.bad_hdr_at) ? 32'd5 : 32'd4;
                    rsp[2] <= (go_cnt == 0) ? cur.o0 : (go_cnt == 1) ? cur.o1 : cur.o2;
                    rsp[3] <= (3'(go_cnt) == cur.dev_err_at) ? 32'd4 : 32'd0;
                    go_cnt <= go_cnt + 1;
                    wr_cnt <= 0; polls <= 0; rd_ptr <= 0;
                end else if (!reg_we && reg_addr == 4'h4) begin
                    polls <= polls + 1;
                    reg_rdata <= {(polls + 1 >= int'(cur.rdy)), 28'd0, cur.serr, 2'd0};
                end else if (!reg_we && reg_addr == 4'hC) begin
                    if (need_zero) begin
                        dfails <= dfails + 1;
                        $display("FAIL R5 read without ack act=1 exp=0");
                    end
                    reg_rdata <= rsp[rd_ptr];
                    need_zero <= 1'b1;
                end else if (reg_we && reg_addr == 4'hC) begin
                    dchecks <= dchecks + 1;
                    if (!need_zero || reg_wdata != 32'd0) begin
                        dfails <= dfails + 1;
                        $display("FAIL R5 ack write act=%0h exp=0", reg_wdata);
                    end
                    need_zero <= 1'b0;
                    if (rd_ptr == 2) dev_off <= rsp[2];
                    rd_ptr <= rd_ptr + 1;
                end else begin
                    dfails <= dfails + 1;
                    $display("FAIL R2 unexpected access act=%0h exp=0", reg_addr);
                end
            end else begin
                reg_ack <= 1'b0;
            end
        end
    end

    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic run_to_done(output bit ok);
        ok = 1'b0;
        for (int c = 0; c < 5000; c++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; break; end
        end
    endtask

    initial begin
        dchecks = 0; dfails = 0;
        cur = VECS[0];
        rst_n = 1'b0; start = 1'b0; image_len = 32'd0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !reg_req, "R1 reset idle", {busy, done, reg_req}, 0);
        chk(err_code == 3'd0 && bytes_sent == 32'd0, "R1 reset values", bytes_sent, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int v = 0; v < NV; v++) begin
            automatic bit got;
            cur = VECS[v];
            image_len = cur.len;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy, "R1 busy after start", busy, 1);
            run_to_done(got);
            chk(got, "R1 done seen", got, 1);
            // R4 R6 R7 R8 R9 R10 result code
            chk(err_code == cur.exp_err, $sformatf("R9 code vec %0d", v), err_code, cur.exp_err);
            chk(bytes_sent == 32'(cur.exp_x) * CB, $sformatf("R11 bytes vec %0d", v), bytes_sent, 32'(cur.exp_x) * CB);
            if (cur.rdy != 4'd1)
                chk(polls == ((cur.rdy > TP) ? TP : int'(cur.rdy)), "R3 R4 poll count", polls, cur.rdy);
            @(negedge clk);
            chk(!done && !busy, "R1 done single cycle", done, 0);
            chk(err_code == cur.exp_err, "R1 code held", err_code, cur.exp_err);
        end
        // R1 reset during a run returns to idle
        cur = VECS[6];
        image_len = cur.len;
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0; @(negedge clk);
        chk(!busy && !reg_req && bytes_sent == 0, "R1 reset mid run", bytes_sent, 0);
        rst_n = 1'b1; @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks + dchecks, fails + dfails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            $display("FAIL watchdog act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks + dchecks + 1, fails + dfails + 1);
            $finish;
        end
    end
endmodule